// File: doc/BRIEF.md
# Write-Through Load-Allocating Data Cache

This block is the first-level data cache that sits beside one processor core. It holds recently loaded 32-byte lines in a four-way set-associative array. A load that finds its line is answered in the cycle it is presented. A load that misses fetches the whole line from the next memory level as eight words. It then completes from the refilled line. Stores never create a line. Every store is sent to the next level as a word write with byte enables. When the line is resident, the same bytes are also merged into the cache.

The set is chosen by address bits `[5 +: SET_BITS]` and the rest of the address above them is the tag. At full size (`SET_BITS` = 7) the set is taken from bits 11:5 and each way spans 4 KiB. The default is smaller so that simulation stays light. Lines whose addresses differ by a multiple of one way's span compete for the same four slots. A per-set recency order picks which slot a new line replaces. A one-cycle `flush` pulse invalidates every line by walking through the sets, one per cycle.

The controller is a four-state machine:
- `ST_IDLE` serves hits and decides what to do next. From it, `go_flush` leads to `ST_FLUSH` on a flush, `go_write` leads to `ST_WRITE` on a store, and `go_fill` leads to `ST_FILL` on a load miss.
- `ST_FILL` returns to `ST_IDLE` through `fill_done` after the eighth word.
- `ST_WRITE` returns to `ST_IDLE` through `write_done` on the acknowledge.
- `ST_FLUSH` returns to `ST_IDLE` through `flush_done` after the last set.

Top module: `wt_dcache`

## Requirements
- R1: A load (cpu_we=0) to a resident line raises cpu_ready in the same cycle it is presented, with cpu_rdata equal to the word at cpu_addr[4:2], and causes no memory request.
- R2: A load to a non-resident line raises mem_fill_req, with mem_fill_addr equal to cpu_addr with bits 4:0 cleared. cpu_ready stays low while mem_fill_req is high. Afterwards the load completes with the memory word.
- R3: A fill accepts exactly eight words, one for each cycle in which mem_fill_valid is high, and stores them at word offsets 0 to 7 in that order. The line becomes valid only after the eighth word, and the load cannot complete in fewer than 9 cycles.
- R4: The way a fill replaces is the lowest-numbered invalid way of the set if one exists. Otherwise it is the least recently used way. Reset ranks way 0 as most recent and the highest way as least recent.
- R5: A completed load hit, a completed fill and a completed store hit each make the way involved the most recently used way of its set.
- R6: Every store (cpu_we=1) raises mem_wr_req with mem_wr_addr equal to cpu_addr with bits 1:0 cleared, mem_wr_data equal to cpu_wdata and mem_wr_be equal to cpu_be. Exactly one write is issued per store. The store completes (cpu_ready) in the cycle mem_wr_ack is high.
- R7: A store to a resident line replaces only the bytes whose cpu_be bit is set (bit b covers data bits 8b+7:8b) in the cached word.
- R8: A store to a non-resident line triggers no fill and leaves residency and recency unchanged.
- R9: Addresses that differ only above the set field map to one set, and at most four of them are resident at once.
- R10: A flush pulse invalidates all lines over 2^SET_BITS cycles and takes precedence over a request presented in the same cycle. A load presented with the pulse sees mem_fill_req after exactly 2^SET_BITS+2 clock edges and never a hit. A flush pulse is never followed in the next cycle by cpu_ready, unless a write was outstanding.
- R11: After reset there are no valid lines, and cpu_ready, mem_fill_req and mem_wr_req are low.
- R12: Eviction writes nothing back. mem_wr_req is raised only while a store is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | One-cycle pulse to invalidate every line |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address (word aligned) |
| cpu_be | input | 4 | Store byte enables |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready on a load |
| mem_fill_req | output | 1 | Line fetch request, held for the whole fill |
| mem_fill_addr | output | ADDR_W | Line-aligned fetch address |
| mem_fill_valid | input | 1 | A fill word is present |
| mem_fill_data | input | 32 | Fill word, delivered in order from word 0 |
| mem_wr_req | output | 1 | Write-through request |
| mem_wr_addr | output | ADDR_W | Word-aligned store address |
| mem_wr_data | output | 32 | Store data |
| mem_wr_be | output | 4 | Store byte enables |
| mem_wr_ack | input | 1 | Next level accepts the write |

## Verification
The flush walk and a load hit can land in the same cycle. The bench makes a line resident, then presents a flush pulse together with a load to that line. It judges that no hit data is returned, and that the fill request appears exactly 2^SET_BITS+2 edges later with the correct line address and data. A store hit can also share its completing cycle with a recency update that a later fill depends on. Random mixes of loads and stores over three heavily aliased sets are checked against a bench model of residency and recency: every predicted hit must answer at once and every predicted miss must fetch exactly one line.

// File: rtl/wt_dcache_pkg.sv
package wt_dcache_pkg;
    localparam int LINE_WORDS  = 8;
    localparam int OFFSET_BITS = 5;
    localparam int WORD_BITS   = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_WRITE,
        ST_FLUSH
    } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int TAG_W = 23,
    parameter int IDX_W = 4,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             wr_en,
    input  logic [WAY_W-1:0] wr_way,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic [WAYS-1:0]  set_valid
);
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else begin
            if (clr_en) valid_q[clr_idx] <= '0;
            if (wr_en)  valid_q[lk_idx][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[lk_idx][wr_way] <= lk_tag;
    end

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (valid_q[lk_idx][w] && tag_q[lk_idx][w] == lk_tag) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    assign set_valid = valid_q[lk_idx];
endmodule

// File: rtl/dc_lru.sv
module dc_lru #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int IDX_W = 4,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [WAYS-1:0]  set_valid,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] victim
);
    // rank 0 = most recent, WAYS-1 = least recent
    logic [WAY_W-1:0] rank_q [SETS][WAYS];
    logic             free_found;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    rank_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    rank_q[idx][w] <= '0;
                else if (rank_q[idx][w] < rank_q[idx][touch_way])
                    rank_q[idx][w] <= rank_q[idx][w] + 1'b1;
            end
        end
    end

    always_comb begin
        victim     = '0;
        free_found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!set_valid[w] && !free_found) begin
                victim     = WAY_W'(w);
                free_found = 1'b1;
            end
        end
        if (!free_found) begin
            for (int w = 0; w < WAYS; w++)
                if (rank_q[idx][w] == WAY_W'(WAYS-1)) victim = WAY_W'(w);
        end
    end
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int IDX_W = 4,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] idx,
    input  logic [WAY_W-1:0] rd_way,
    input  logic [2:0]       rd_word,
    output logic [31:0]      rd_data,
    input  logic             wr_en,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [2:0]       wr_word,
    input  logic [31:0]      wr_data,
    input  logic [3:0]       wr_be
);
    localparam int AW    = IDX_W + WAY_W + 3;
    localparam int DEPTH = SETS * WAYS * 8;

    logic [31:0]   mem_q [DEPTH];
    logic [AW-1:0] rd_a, wr_a;

    assign rd_a    = {idx, rd_way, rd_word};
    assign wr_a    = {idx, wr_way, wr_word};
    assign rd_data = mem_q[rd_a];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < 4; b++)
                if (wr_be[b]) mem_q[wr_a][8*b +: 8] <= wr_data[8*b +: 8];
        end
    end
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
    import wt_dcache_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SET_BITS = 4,
    parameter int WAYS     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [3:0]        cpu_be,
    input  logic [31:0]       cpu_wdata,
    output logic              cpu_ready,
    output logic [31:0]       cpu_rdata,
    output logic              mem_fill_req,
    output logic [ADDR_W-1:0] mem_fill_addr,
    input  logic              mem_fill_valid,
    input  logic [31:0]       mem_fill_data,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic [3:0]        mem_wr_be,
    input  logic              mem_wr_ack
);
    localparam int SETS  = 1 << SET_BITS;
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = ADDR_W - OFFSET_BITS - SET_BITS;
    localparam logic [SET_BITS-1:0]  LAST_SET  = SET_BITS'(SETS - 1);
    localparam logic [WORD_BITS-1:0] LAST_WORD = WORD_BITS'(LINE_WORDS - 1);

    dc_state_e state_q, state_d;

    logic [SET_BITS-1:0]  req_idx, flush_cnt_q;
    logic [TAG_W-1:0]     req_tag;
    logic [WORD_BITS-1:0] req_word, fill_cnt_q;
    logic [WAY_W-1:0]     victim_q, lru_victim, hit_way;
    logic [WAYS-1:0]      set_valid;
    logic                 hit, flush_pend_q, go_flush;
    logic                 load_hit_ok, store_hit_done, fill_done, fill_beat;
    logic                 unused_addr_bits;

    assign req_idx  = cpu_addr[OFFSET_BITS +: SET_BITS];
    assign req_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_word = cpu_addr[2 +: WORD_BITS];
    assign unused_addr_bits = ^cpu_addr[1:0];

    assign go_flush       = flush | flush_pend_q;
    assign load_hit_ok    = cpu_req && !cpu_we && hit && !go_flush;
    assign fill_beat      = (state_q == ST_FILL) && mem_fill_valid;
    assign fill_done      = fill_beat && (fill_cnt_q == LAST_WORD);
    assign store_hit_done = (state_q == ST_WRITE) && mem_wr_ack && hit;

    dc_tag_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(SET_BITS), .WAY_W(WAY_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (req_idx),
        .lk_tag   (req_tag),
        .wr_en    (fill_done),
        .wr_way   (victim_q),
        .clr_en   (state_q == ST_FLUSH),
        .clr_idx  (flush_cnt_q),
        .hit      (hit),
        .hit_way  (hit_way),
        .set_valid(set_valid)
    );

    dc_lru #(
        .SETS(SETS), .WAYS(WAYS), .IDX_W(SET_BITS), .WAY_W(WAY_W)
    ) u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (req_idx),
        .set_valid(set_valid),
        .touch_en ((state_q == ST_IDLE && load_hit_ok) || store_hit_done || fill_done),
        .touch_way(fill_done ? victim_q : hit_way),
        .victim   (lru_victim)
    );

    dc_data_store #(
        .SETS(SETS), .WAYS(WAYS), .IDX_W(SET_BITS), .WAY_W(WAY_W)
    ) u_data (
        .clk    (clk),
        .idx    (req_idx),
        .rd_way (hit_way),
        .rd_word(req_word),
        .rd_data(cpu_rdata),
        .wr_en  (fill_beat || store_hit_done),
        .wr_way (fill_beat ? victim_q : hit_way),
        .wr_word(fill_beat ? fill_cnt_q : req_word),
        .wr_data(fill_beat ? mem_fill_data : cpu_wdata),
        .wr_be  (fill_beat ? 4'hF : cpu_be)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_flush)                state_d = ST_FLUSH;   // go_flush
                else if (cpu_req && cpu_we)  state_d = ST_WRITE;   // go_write
                else if (cpu_req && !hit)    state_d = ST_FILL;    // go_fill
            end
            ST_FILL:  if (fill_done)                  state_d = ST_IDLE;
            ST_WRITE: if (mem_wr_ack)                 state_d = ST_IDLE;
            ST_FLUSH: if (flush_cnt_q == LAST_SET)    state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            fill_cnt_q   <= '0;
            flush_cnt_q  <= '0;
            flush_pend_q <= 1'b0;
            victim_q     <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE)      flush_pend_q <= 1'b0;
            else if (flush)              flush_pend_q <= 1'b1;
            if (state_q == ST_IDLE && state_d == ST_FILL) victim_q <= lru_victim;
            if (fill_beat)               fill_cnt_q <= fill_cnt_q + 1'b1;
            if (state_q == ST_FLUSH)     flush_cnt_q <= flush_cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        cpu_ready    = 1'b0;
        mem_fill_req = 1'b0;
        mem_wr_req   = 1'b0;
        unique case (state_q)
            ST_IDLE:  cpu_ready = load_hit_ok;
            ST_FILL:  mem_fill_req = 1'b1;
            ST_WRITE: begin
                mem_wr_req = 1'b1;
                cpu_ready  = mem_wr_ack;
            end
            ST_FLUSH: cpu_ready = 1'b0;
            default:  cpu_ready = 1'b0;
        endcase
    end

    assign mem_fill_addr = {cpu_addr[ADDR_W-1:OFFSET_BITS], {OFFSET_BITS{1'b0}}};
    assign mem_wr_addr   = {cpu_addr[ADDR_W-1:2], 2'b00};
    assign mem_wr_data   = cpu_wdata;
    assign mem_wr_be     = cpu_be;
endmodule

// File: rtl/wt_dcache_checker.sv
module wt_dcache_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_ready,
    input logic              mem_fill_req,
    input logic [ADDR_W-1:0] mem_fill_addr,
    input logic              mem_wr_req,
    input logic              mem_wr_ack
);
    a_r1_ready_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);

    a_r2_stall_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
        mem_fill_req |-> !cpu_ready);

    a_r2_fill_line_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_fill_req |-> (mem_fill_addr[4:0] == 5'd0 &&
                          mem_fill_addr[ADDR_W-1:5] == cpu_addr[ADDR_W-1:5]));

    a_r6_store_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_we) |-> mem_wr_ack);

    a_r6_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=> mem_wr_req);

    a_r10_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !mem_wr_req) |=> !cpu_ready);

    a_r12_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> (cpu_req && cpu_we));
endmodule

bind wt_dcache wt_dcache_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .cpu_addr     (cpu_addr),
    .cpu_ready    (cpu_ready),
    .mem_fill_req (mem_fill_req),
    .mem_fill_addr(mem_fill_addr),
    .mem_wr_req   (mem_wr_req),
    .mem_wr_ack   (mem_wr_ack)
);

// File: tb/wt_dcache_test.sv
module wt_dcache_test;
    localparam int SB   = 4;
    localparam int SETS = 1 << SB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = 4'hF;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_fill_req, mem_fill_valid = 1'b0;
    logic [31:0] mem_fill_addr, mem_fill_data = '0;
    logic        mem_wr_req, mem_wr_ack = 1'b0;
    logic [31:0] mem_wr_addr, mem_wr_data;
    logic [3:0]  mem_wr_be;

    always #2 clk = ~clk;

    wt_dcache #(.ADDR_W(32), .SET_BITS(SB), .WAYS(4)) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_fill_req(mem_fill_req), .mem_fill_addr(mem_fill_addr),
        .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_be(mem_wr_be), .mem_wr_ack(mem_wr_ack)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [31:0] memw [logic [29:0]];

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (memw.exists(a[31:2])) return memw[a[31:2]];
        return (a * 32'h9E3779B1) ^ 32'h5A5A_5A5A;
    endfunction

    int          fill_events = 0, wr_events = 0;
    logic [31:0] last_fill_addr = '0, last_wr_addr = '0, last_wr_data = '0;
    logic [3:0]  last_wr_be = '0;

    initial begin
        int fcnt = 0;
        int wdly = 1;
        bit started = 0;
        logic [31:0] old;
        forever begin
            @(negedge clk);
            mem_fill_valid = 1'b0;
            if (mem_fill_req) begin
                if (!started) begin
                    started = 1;
                    fill_events++;
                    last_fill_addr = mem_fill_addr;
                end
                if (fcnt < 8 && ($urandom % 4) != 0) begin
                    mem_fill_valid = 1'b1;
                    mem_fill_data  = mem_rd(mem_fill_addr + 32'(fcnt * 4));
                    fcnt++;
                end
            end else begin
                fcnt = 0;
                started = 0;
            end
            if (mem_wr_ack) mem_wr_ack = 1'b0;
            else if (mem_wr_req) begin
                if (wdly == 0) begin
                    mem_wr_ack = 1'b1;
                    wr_events++;
                    last_wr_addr = mem_wr_addr;
                    last_wr_data = mem_wr_data;
                    last_wr_be   = mem_wr_be;
                    old = mem_rd(mem_wr_addr);
                    for (int b = 0; b < 4; b++)
                        if (mem_wr_be[b]) old[8*b +: 8] = mem_wr_data[8*b +: 8];
                    memw[mem_wr_addr[31:2]] = old;
                    wdly = $urandom % 3;
                end else wdly--;
            end
        end
    end

    // ---------------- cache model ----------------
    logic [22:0] mtag [SETS][4];
    bit          mval [SETS][4];
    int          mage [SETS][4];

    function automatic int model_way(input logic [31:0] a);
        for (int w = 0; w < 4; w++)
            if (mval[a[8:5]][w] && mtag[a[8:5]][w] == a[31:9]) return w;
        return -1;
    endfunction

    function automatic void model_touch(input int s, input int w);
        int r = mage[s][w];
        for (int k = 0; k < 4; k++) if (mage[s][k] < r) mage[s][k]++;
        mage[s][w] = 0;
    endfunction

    function automatic int model_victim(input int s);
        for (int w = 0; w < 4; w++) if (!mval[s][w]) return w;
        for (int w = 0; w < 4; w++) if (mage[s][w] == 3) return w;
        return 0;
    endfunction

    function automatic void model_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < 4; w++) begin
                mval[s][w] = 0;
                mage[s][w] = w;
            end
    endfunction

    function automatic logic [31:0] mk(input int tg, input int st, input int wd);
        return 32'((tg << 9) | (st << 5) | (wd << 2));
    endfunction

    // ---------------- processor tasks ----------------
    task automatic do_load(input logic [31:0] a);
        int w, cyc, f0, v;
        bit wr_seen;
        logic [31:0] got, exp;
        w = model_way(a);
        f0 = fill_events;
        wr_seen = 0;
        cpu_addr = a; cpu_we = 1'b0; cpu_req = 1'b1;
        cyc = 0;
        #1;
        while (!cpu_ready && cyc < 400) begin
            if (mem_wr_req) wr_seen = 1;
            @(negedge clk); cyc++; #1;
        end
        got = cpu_rdata;
        exp = mem_rd(a);
        @(negedge clk);
        cpu_req = 1'b0;
        chk(got == exp, "R2 load data", got, exp);
        chk(!wr_seen, "R12 no write during load", 32'(wr_seen), 0);
        if (w >= 0) begin
            chk(cyc == 0, "R1 hit in same cycle", 32'(cyc), 0);
            chk(fill_events == f0, "R1 hit fetches nothing", 32'(fill_events - f0), 0);
            model_touch(a[8:5], w);
        end else begin
            chk(fill_events == f0 + 1, "R2 one fill per miss", 32'(fill_events - f0), 1);
            chk(last_fill_addr == {a[31:5], 5'b0}, "R2 fill address", last_fill_addr, {a[31:5], 5'b0});
            chk(cyc >= 9, "R3 eight-word fill latency", 32'(cyc), 9);
            v = model_victim(a[8:5]);
            mval[a[8:5]][v] = 1;
            mtag[a[8:5]][v] = a[31:9];
            model_touch(a[8:5], v);
        end
    endtask

    task automatic do_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        int w, cyc, f0, w0;
        w = model_way(a);
        f0 = fill_events;
        w0 = wr_events;
        cpu_addr = a; cpu_we = 1'b1; cpu_wdata = d; cpu_be = be; cpu_req = 1'b1;
        cyc = 0;
        #1;
        while (!cpu_ready && cyc < 400) begin
            @(negedge clk); cyc++; #1;
        end
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        chk(wr_events == w0 + 1, "R6 one write per store", 32'(wr_events - w0), 1);
        chk(last_wr_addr == {a[31:2], 2'b0}, "R6 write address", last_wr_addr, {a[31:2], 2'b0});
        chk(last_wr_data == d, "R6 write data", last_wr_data, d);
        chk(last_wr_be == be, "R6 write enables", 32'(last_wr_be), 32'(be));
        chk(fill_events == f0, "R8 store never fills", 32'(fill_events - f0), 0);
        if (w >= 0) model_touch(a[8:5], w);
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        repeat (SETS + 2) @(negedge clk);
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < 4; w++) mval[s][w] = 0;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!cpu_ready && !mem_fill_req && !mem_wr_req, "R11 idle outputs after reset",
            {29'd0, cpu_ready, mem_fill_req, mem_wr_req}, 0);
        @(negedge clk);

        // R11: first access misses
        do_load(mk(1, 0, 0));

        // R4 / R5 / R9: five lines aliasing one set
        for (int t = 0; t < 4; t++) do_load(mk(20 + t, 3, t));
        do_load(mk(20, 3, 5));              // R5 touch way of tag 20
        do_load(mk(24, 3, 1));              // R4 evicts least recent (tag 21)
        do_load(mk(21, 3, 2));              // R9 tag 21 must miss
        do_load(mk(20, 3, 7));              // still resident
        do_load(mk(23, 3, 0));

        // R7: store hit merges bytes, R8: store miss does not allocate
        do_store(mk(20, 3, 3), 32'hDEAD_BEEF, 4'b0010);
        do_load(mk(20, 3, 3));
        do_store(mk(40, 3, 4), 32'h1234_5678, 4'b1111);
        do_load(mk(40, 3, 4));              // R8: must miss
        do_store(mk(40, 3, 6), 32'hCAFE_F00D, 4'b1001);
        do_load(mk(40, 3, 6));              // R7 resident merge

        // R10: flush together with a load that would hit
        begin
            int k = 0;
            bit rdy_early = 0;
            logic [31:0] a = mk(40, 3, 6);
            chk(model_way(a) >= 0, "R10 line resident before flush", 0, 1);
            flush = 1'b1;
            cpu_addr = a; cpu_we = 1'b0; cpu_req = 1'b1;
            #1;
            if (cpu_ready) rdy_early = 1;
            while (!mem_fill_req && k < 400) begin
                @(negedge clk);
                k++;
                if (k == 1) flush = 1'b0;
                #1;
                if (cpu_ready) rdy_early = 1;
            end
            chk(!rdy_early, "R10 flush wins over hit", 32'(rdy_early), 0);
            chk(k == SETS + 2, "R10 flush duration", 32'(k), 32'(SETS + 2));
            while (!cpu_ready && k < 400) begin @(negedge clk); k++; #1; end
            chk(cpu_rdata == mem_rd(a), "R10 data after flush", cpu_rdata, mem_rd(a));
            @(negedge clk);
            cpu_req = 1'b0;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < 4; w++) mval[s][w] = 0;
            mval[3][0] = 1; mtag[3][0] = a[31:9]; model_touch(3, 0);
        end

        // random mix over three aliased sets
        for (int n = 0; n < 700; n++) begin
            int st, tg, wd, op;
            logic [3:0] be;
            st = (n % 3 == 0) ? 0 : ((n % 3 == 1) ? 9 : 15);
            tg = $urandom % 6;
            wd = $urandom % 8;
            op = $urandom % 40;
            if (op == 0) do_flush();
            else if (op < 26) do_load(mk(tg, st, wd));
            else begin
                be = 4'($urandom % 15 + 1);
                do_store(mk(tg, st, wd), $urandom, be);
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule